// File: doc/BRIEF.md
# Eight-bit accumulator ALU with status flags

This block is the arithmetic and logic datapath of a small eight-bit accumulator machine. In one combinational pass it turns an operation code, the accumulator value and a second operand into an eight-bit result. It also produces a five-bit status vector and a per-flag write-enable mask. The status vector holds sign, zero, half carry (carry out of the low nibble), even parity and carry. Each operation class writes its own subset of these flags, and some classes force fixed values.

The block keeps its own five-bit flag register. The carry and half-carry held there feed the operations that need them: carry-in, borrow-in, decimal adjust and rotates through carry. When `en` is high, the register takes the new value of every enabled flag at the clock edge and keeps every other flag. The surrounding core owns decode, register storage and memory. It presents one operation per cycle and raises `en` when that operation should commit its flags.

Top module: `alu8_core`

## Requirements
- R1: Codes 0 (add) and 1 (add with carry): result = (acc + opnd + cin) mod 256, where cin is the stored carry for code 1 and 0 for code 0. Carry = carry out of bit 7, half carry = carry out of bit 3. All five write enables are set.
- R2: Codes 2 (subtract) and 3 (subtract with borrow): result = (acc − opnd − bin) mod 256, where bin is the stored carry for code 3 and 0 for code 2. Carry = 1 when a borrow occurs (acc < opnd + bin). Half carry = 1 when the low nibble needs no borrow (acc[3:0] ≥ opnd[3:0] + bin). All five enables are set.
- R3: Code 4 gives opnd + 1, with half carry = 1 when opnd[3:0] = Fh. Code 5 gives opnd − 1, with half carry = 1 when opnd[3:0] ≠ 0. Both set the sign, zero, half-carry and parity enables and leave the carry enable clear.
- R4: Code 6 (AND) forces half carry to 1 and carry to 0. Codes 7 (OR) and 8 (XOR) force both to 0. All three set all five enables.
- R5: Code 9 returns the bitwise inverse of acc and sets no write enable.
- R6: The flag vector is laid out as bit 4 sign, bit 3 zero, bit 2 half carry, bit 1 parity, bit 0 carry. Whenever their enables are set, sign = result bit 7, zero = (result == 00h), and parity = 1 for an even number of one bits in the result.
- R7: Code 10 (decimal adjust) adds 06h when acc[3:0] > 9 or the stored half carry is 1. Half carry becomes the carry out of bit 3 of that step. It then adds 60h when the high nibble of the intermediate value is > 9, or that step carried out of bit 7, or the stored carry is 1. Carry becomes 1 in that case and otherwise keeps its stored value. All five enables are set.
- R8: Codes 11 to 14 are rotates that set only the carry enable. Code 11 rotates left and copies bit 7 into bit 0 and carry. Code 12 rotates right and copies bit 0 into bit 7 and carry. Code 13 rotates left, with the stored carry entering bit 0 and bit 7 going to carry. Code 14 rotates right, with the stored carry entering bit 7 and bit 0 going to carry.
- R9: Code 15 passes acc to the result and sets no write enable.
- R10: At a rising clock edge with en = 1, each flag register bit with its enable set takes its new value, and every other bit holds. With en = 0, the register holds entirely.
- R11: flags_nxt shows the new value for every enabled flag and the registered value for every other flag.
- R12: An active-low asynchronous reset clears the flag register to 00000b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Commit this operation's flags at the next edge |
| op | input | 4 | Operation code (0 to 15) |
| acc | input | 8 | Accumulator operand |
| opnd | input | 8 | Second operand |
| result | output | 8 | Operation result |
| flags_nxt | output | 5 | Merged flag vector after this operation |
| flag_we | output | 5 | Per-flag write enable |
| flags_q | output | 5 | Registered flags |

## Verification
The sweep covers every operation for all accumulator values, sixteen spread operand values and all four combinations of stored carry and half carry. This reaches the points where sloppy logic breaks. One is the half carry of subtraction, which is easy to invert into a borrow flag. Another is decimal adjust across the carry out of the low-nibble correction (acc = FAh), where a design that ignores that carry leaves the high digit uncorrected. A third is the stored carry in decimal adjust, which a wrong design would clear. Increment, decrement, complement, pass and the rotates are checked for stray enables, because a design that lets them write carry or other flags corrupts state without changing the result. The register is exercised with en low to show that it truly holds.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = 4;
  localparam int FLAG_N = 5;

  localparam int F_SGN = 4;
  localparam int F_ZRO = 3;
  localparam int F_HLF = 2;
  localparam int F_PAR = 1;
  localparam int F_CRY = 0;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_NOT  = 4'd9,
    OP_DADJ = 4'd10,
    OP_ROL  = 4'd11,
    OP_ROR  = 4'd12,
    OP_RCL  = 4'd13,
    OP_RCR  = 4'd14,
    OP_PASS = 4'd15
  } alu_op_e;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8,
  parameter int H = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co,
  output logic         hc
);
  logic [W:0] full;
  logic [H:0] low;

  always_comb begin
    full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    low  = {1'b0, x[H-1:0]} + {1'b0, y[H-1:0]} + {{H{1'b0}}, ci};
    s    = full[W-1:0];
    co   = full[W];
    hc   = low[H];
  end
endmodule

// File: rtl/alu8_dadj.sv
module alu8_dadj #(
  parameter int W = 8,
  parameter int H = 4
) (
  input  logic [W-1:0] a,
  input  logic         hc_in,
  input  logic         cy_in,
  output logic [W-1:0] r,
  output logic         hc_out,
  output logic         cy_out
);
  localparam logic [H-1:0] DIGIT_MAX = H'(9);
  localparam logic [H:0]   LO_FIX    = (H+1)'(6);
  localparam logic [W:0]   HI_FIX    = (W+1)'(6) << H;

  logic         lo_need;
  logic         hi_need;
  logic [H:0]   lo_sum;
  logic [W:0]   step1;
  logic [W:0]   step2;

  always_comb begin
    lo_need = (a[H-1:0] > DIGIT_MAX) || hc_in;
    lo_sum  = {1'b0, a[H-1:0]} + (lo_need ? LO_FIX : '0);
    step1   = {1'b0, a} + (lo_need ? (W+1)'(LO_FIX) : '0);
    hi_need = (step1[W-1:H] > (W-H)'(9)) || step1[W] || cy_in;
    step2   = {1'b0, step1[W-1:0]} + (hi_need ? HI_FIX : '0);
    r       = step2[W-1:0];
    hc_out  = lo_sum[H];
    cy_out  = cy_in | hi_need;
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cy_in,
  output logic [W-1:0] r,
  output logic         cy_out
);
  always_comb begin
    r      = a;
    cy_out = cy_in;
    unique case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_NOT:  r = ~a;
      OP_ROL: begin
        r      = {a[W-2:0], a[W-1]};
        cy_out = a[W-1];
      end
      OP_ROR: begin
        r      = {a[0], a[W-1:1]};
        cy_out = a[0];
      end
      OP_RCL: begin
        r      = {a[W-2:0], cy_in};
        cy_out = a[W-1];
      end
      OP_RCR: begin
        r      = {cy_in, a[W-1:1]};
        cy_out = a[0];
      end
      default: r = a;
    endcase
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] q_next;

  always_comb begin
    q_next = q;
    if (en) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_N-1:0] flags_nxt,
  output logic [FLAG_N-1:0] flag_we,
  output logic [FLAG_N-1:0] flags_q
);
  alu_op_e           op_e;
  logic [DATA_W-1:0] add_x, add_y, add_s;
  logic              add_ci, add_co, add_hc;
  logic [DATA_W-1:0] dadj_r, lg_r;
  logic              dadj_hc, dadj_cy, lg_cy;
  logic              cy_cur, hc_cur;
  logic              hc_sel, cy_sel;
  logic [FLAG_N-1:0] flag_new;

  assign op_e   = alu_op_e'(op);
  assign cy_cur = flags_q[F_CRY];
  assign hc_cur = flags_q[F_HLF];

  // adder operand steering: subtraction runs as x + ~y + ~borrow
  always_comb begin
    add_x  = acc;
    add_y  = opnd;
    add_ci = 1'b0;
    unique case (op_e)
      OP_ADC: add_ci = cy_cur;
      OP_SUB: begin
        add_y  = ~opnd;
        add_ci = 1'b1;
      end
      OP_SBC: begin
        add_y  = ~opnd;
        add_ci = ~cy_cur;
      end
      OP_INC: begin
        add_x  = opnd;
        add_y  = '0;
        add_ci = 1'b1;
      end
      OP_DEC: begin
        add_x  = opnd;
        add_y  = '1;
      end
      default: ;
    endcase
  end

  alu8_adder #(.W(DATA_W), .H(NIB_W)) u_add (
    .x(add_x), .y(add_y), .ci(add_ci), .s(add_s), .co(add_co), .hc(add_hc)
  );

  alu8_dadj #(.W(DATA_W), .H(NIB_W)) u_dadj (
    .a(acc), .hc_in(hc_cur), .cy_in(cy_cur),
    .r(dadj_r), .hc_out(dadj_hc), .cy_out(dadj_cy)
  );

  alu8_logic #(.W(DATA_W)) u_logic (
    .op(op_e), .a(acc), .b(opnd), .cy_in(cy_cur), .r(lg_r), .cy_out(lg_cy)
  );

  // result, class flags and write enables
  always_comb begin
    result  = lg_r;
    hc_sel  = 1'b0;
    cy_sel  = lg_cy;
    flag_we = '0;
    unique case (op_e)
      OP_ADD, OP_ADC: begin
        result  = add_s;
        hc_sel  = add_hc;
        cy_sel  = add_co;
        flag_we = '1;
      end
      OP_SUB, OP_SBC: begin
        result  = add_s;
        hc_sel  = add_hc;
        cy_sel  = ~add_co;
        flag_we = '1;
      end
      OP_INC, OP_DEC: begin
        result           = add_s;
        hc_sel           = add_hc;
        flag_we          = '1;
        flag_we[F_CRY]   = 1'b0;
      end
      OP_AND: begin
        hc_sel  = 1'b1;
        cy_sel  = 1'b0;
        flag_we = '1;
      end
      OP_OR, OP_XOR: begin
        cy_sel  = 1'b0;
        flag_we = '1;
      end
      OP_DADJ: begin
        result  = dadj_r;
        hc_sel  = dadj_hc;
        cy_sel  = dadj_cy;
        flag_we = '1;
      end
      OP_ROL, OP_ROR, OP_RCL, OP_RCR: flag_we[F_CRY] = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    flag_new        = '0;
    flag_new[F_SGN] = result[DATA_W-1];
    flag_new[F_ZRO] = (result == '0);
    flag_new[F_HLF] = hc_sel;
    flag_new[F_PAR] = ~^result;
    flag_new[F_CRY] = cy_sel;
    flags_nxt       = (flag_new & flag_we) | (flags_q & ~flag_we);
  end

  alu8_flagreg #(.N(FLAG_N)) u_freg (
    .clk(clk), .rst_n(rst_n), .en(en), .d(flags_nxt), .q(flags_q)
  );
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [3:0] op,
  input logic [7:0] acc,
  input logic [7:0] result,
  input logic [4:0] flags_nxt,
  input logic [4:0] flag_we,
  input logic [4:0] flags_q
);
  // R10
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> flags_q == $past(flags_nxt));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(flags_q));
  // R11
  merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_nxt ^ flags_q) & ~flag_we) == 5'b0);
  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we[3] |-> flags_nxt[3] == (result == 8'h00));
  // R6
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we[1] |-> flags_nxt[1] == ~^result);
  // R6
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we[4] |-> flags_nxt[4] == result[7]);
  // R3
  incdec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd4 || op == 4'd5) |-> !flag_we[0]);
  // R4
  and_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'd6 |-> flags_nxt[2] && !flags_nxt[0]);
  // R5
  not_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'd9 |-> flag_we == 5'b0 && result == ~acc);
  // R8
  rotate_only_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= 4'd11 && op <= 4'd14) |-> flag_we == 5'b00001);
endmodule

bind alu8_core alu8_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .op(op), .acc(acc), .result(result),
  .flags_nxt(flags_nxt), .flag_we(flag_we), .flags_q(flags_q)
);

// File: tb/alu8_core_test.sv
module alu8_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 120000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [3:0] op;
  logic [7:0] acc, opnd;
  logic [7:0] result;
  logic [4:0] flags_nxt, flag_we, flags_q;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  alu8_core uut (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .acc(acc), .opnd(opnd),
    .result(result), .flags_nxt(flags_nxt), .flag_we(flag_we), .flags_q(flags_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_CYCLES) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < %0d", cycles, WD_CYCLES);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  function automatic string req_of(input int o);
    case (o)
      0, 1:           return "R1";
      2, 3:           return "R2";
      4, 5:           return "R3";
      6, 7, 8:        return "R4";
      9:              return "R5";
      10:             return "R7";
      11, 12, 13, 14: return "R8";
      default:        return "R9";
    endcase
  endfunction

  // reference model built from the requirement text
  task automatic model(input int o, input int a, input int b, input bit cy, input bit hc,
                       output logic [7:0] r, output logic [4:0] fv, output logic [4:0] we);
    int t, c, h, lo, hi;
    c = cy; h = 0; we = 5'b11111;
    case (o)
      0, 1: begin
        lo = (o == 1) ? cy : 0;
        t = a + b + lo;
        c = t / 256; h = ((a % 16) + (b % 16) + lo) / 16;
      end
      2, 3: begin
        lo = (o == 3) ? cy : 0;
        t = a - b - lo;
        c = (a < b + lo); h = ((a % 16) >= (b % 16) + lo);
      end
      4: begin t = b + 1; h = (b % 16 == 15); we = 5'b11110; end
      5: begin t = b + 255; h = (b % 16 != 0); we = 5'b11110; end
      6: begin t = a & b; h = 1; c = 0; end
      7: begin t = a | b; c = 0; end
      8: begin t = a ^ b; c = 0; end
      9: begin t = 255 - a; we = 0; end
      10: begin
        lo = ((a % 16) > 9) || hc;
        t = a + (lo ? 6 : 0);
        h = ((a % 16) + (lo ? 6 : 0)) >= 16;
        hi = (((t / 16) % 16) > 9) || (t >= 256) || cy;
        t = (t % 256) + (hi ? 96 : 0);
        c = cy || hi;
      end
      11: begin t = (a * 2) % 256 + a / 128; c = a / 128; we = 5'b00001; end
      12: begin t = a / 2 + (a % 2) * 128; c = a % 2; we = 5'b00001; end
      13: begin t = (a * 2) % 256 + cy; c = a / 128; we = 5'b00001; end
      14: begin t = a / 2 + cy * 128; c = a % 2; we = 5'b00001; end
      default: begin t = a; we = 0; end
    endcase
    r = 8'(t & 255);
    fv = {r[7], r == 8'h00, h[0], ~^r, c[0]};
  endtask

  task automatic step(input int o, input int a, input int b, input bit e);
    @(negedge clk);
    op = 4'(o); acc = 8'(a); opnd = 8'(b); en = e;
    @(posedge clk);
    #1;
    en = 1'b0;
  endtask

  task automatic check5(input string req, input logic [4:0] got, input logic [4:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // R4 R8 R10: force half carry and carry to chosen values, known S=0 Z=1 P=1
  task automatic set_flags(input bit cy, input bit hc);
    step(hc ? 6 : 7, 0, 0, 1'b1);
    step(11, cy ? 8'h80 : 8'h00, 0, 1'b1);
    check5("R10", flags_q, {1'b0, 1'b1, hc, 1'b1, cy});
  endtask

  task automatic check_op(input int o, input int a, input int b, input bit cy, input bit hc);
    logic [7:0] r;
    logic [4:0] fv, we, cur, exp;
    model(o, a, b, cy, hc, r, fv, we);
    cur = {1'b0, 1'b1, hc, 1'b1, cy};
    exp = (fv & we) | (cur & ~we);
    op = 4'(o); acc = 8'(a); opnd = 8'(b);
    #1;
    n_checks++;
    if (result !== r || flag_we !== we || flags_nxt !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h cy=%0d hc=%0d: got r=%h we=%b f=%b expected r=%h we=%b f=%b",
               req_of(o), o, a, b, cy, hc, result, flag_we, flags_nxt, r, we, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; op = 4'd15; acc = 8'h00; opnd = 8'h00;
    #(CLK_PERIOD * 2 + 2);
    // R12: reset clears the flag register
    check5("R12", flags_q, 5'b00000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check5("R12", flags_q, 5'b00000);

    // R1: 9Ah + 89h = 23h with carry and half carry
    set_flags(0, 0);
    check_op(0, 8'h9A, 8'h89, 0, 0);
    // R2: 40h - 20h - 1 = 1Fh
    set_flags(1, 0);
    check_op(3, 8'h40, 8'h20, 1, 0);
    // R4 R6: 62h AND 4Ah = 42h, parity even
    set_flags(0, 0);
    check_op(6, 8'h62, 8'h4A, 0, 0);
    check5("R6", flags_nxt, 5'b00110);
    // R5: complement 9Ah -> 65h
    check_op(9, 8'h9A, 8'h00, 0, 0);
    // R7: 6Ch -> 72h with half carry set
    check_op(10, 8'h6C, 8'h00, 0, 0);
    // R7: FAh crosses both corrections
    check_op(10, 8'hFA, 8'h00, 0, 0);

    // R10: en low holds the register across a flag-writing op
    set_flags(1, 1);
    step(0, 8'h9A, 8'h89, 1'b0);
    check5("R10", flags_q, 5'b01111);
    // R10 R11: committing RLC touches only carry
    step(11, 8'h01, 8'h00, 1'b1);
    check5("R10", flags_q, 5'b01110);
    op = 4'd15; #1;
    check5("R11", flags_nxt, flags_q);
    // R10: commit of full-flag op 9Ah+89h -> S0 Z0 H1 P0 C1
    step(0, 8'h9A, 8'h89, 1'b1);
    check5("R10", flags_q, 5'b00101);

    // sweep: every op, every acc, spread operands, all stored carry/half-carry pairs
    for (int o = 0; o < 16; o++) begin
      for (int f = 0; f < 4; f++) begin
        set_flags(f[0], f[1]);
        for (int a = 0; a < 256; a++) begin
          for (int j = 0; j < 16; j++) begin
            check_op(o, a, (j * 37 + 5) % 256, f[0], f[1]);
          end
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule